// File: doc/BRIEF.md
# Segment Step-Error Code Corrector

This block sits right after the digital correction logic of a two-stage pipelined ADC. It removes the periodic code jump between neighbouring coarse segments. In every sample cycle it receives three things: the unsigned raw output code, the first-stage coarse code that tells which segment the sample belongs to, and a signed step-error estimate.

The block moves the raw code by the step error multiplied by an odd weight. The weight is the coarse segment's signed distance from mid-scale. Segments below the centre therefore move down, and segments above it move up, by equal and opposite amounts. The corrected code is a wider two's complement fixed-point value and keeps the fractional bits of the step error.

An external tracking loop produces the step-error estimate and updates it slowly. The estimate is loaded into a local holding register only when an update strobe is asserted. Every sample between two strobes is therefore corrected with the same value, even if the input bus moves in the meantime.

Top module: `seg_step_corrector`

## Requirements
- R1: For each valid sample, the corrected output equals raw·32 + step·(2·coarse − 15). The raw code is unsigned, step is the held 12-bit two's complement estimate with 5 fractional bits, and the output is an 18-bit two's complement value with 5 fractional bits. The output appears two clock cycles after the sample is presented.
- R2: The output valid flag repeats the sample valid input delayed by exactly two clock cycles.
- R3: The output never overflows over the whole input range. The extremes are −30720 (raw 0, step −2048, coarse 15) and 63456 (raw 1023, step −2048, coarse 0).
- R4: A change of the step input without the update strobe has no effect on any later corrected output.
- R5: When the update strobe is high at a clock edge, the held step takes the step input value. A sample presented in the same cycle as the strobe still uses the previous held value. Samples presented from the next cycle onward use the new value.
- R6: Synchronous active-high reset clears the held step, the output and the output valid flag to zero. Until the first strobe, samples pass through as raw·32.
- R7: The weight for coarse code c is 2c − 15. Coarse 0 gives −15, 7 gives −1, 8 gives +1 and 15 gives +15, so codes c and 15 − c give corrections of opposite sign and equal size.
- R8: While no valid sample flows through the pipeline, the corrected output holds its last value.
- R9: Negative corrected values come out as correctly sign-extended two's complement numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld_i | input | 1 | Sample valid |
| raw_i | input | 10 | Unsigned raw ADC code |
| crs_i | input | 4 | Coarse segment index from the first stage |
| step_i | input | 12 | Step-error estimate, two's complement, 5 fractional bits |
| step_upd_i | input | 1 | Load strobe for the step-error holding register |
| corr_o | output | 18 | Corrected code, two's complement, 5 fractional bits |
| corr_vld_o | output | 1 | Corrected code valid |

## Verification
The in-RTL assertions check the following on every cycle:
- the holding register stays put without a strobe and loads the input value with a strobe;
- a zero held step gives a zero product;
- the corrected sum stays inside the range R3 derives;
- the output holds while no valid sample arrives.

Only the bench scenarios can show the rest:
- the arithmetic value against the weight table;
- the two-cycle alignment of data and valid;
- which step value a sample taken in the strobe cycle uses;
- the mirror symmetry between opposite segments;
- correct signs at the negative extreme.

// File: rtl/segcorr_pkg.sv
package segcorr_pkg;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Multiplier implementation options
   localparam int MULT_NATIVE   = 0;
   localparam int MULT_SHIFTADD = 1;

endpackage

// File: rtl/seg_weight.sv
// Maps a coarse segment index to its odd, mid-centred signed weight 2c-(2^N-1).
module seg_weight #(
   parameter int CRS_W = 4,
   localparam int WGT_W = CRS_W + 1
) (
   input  logic [CRS_W-1:0]        crs_i,
   output logic signed [WGT_W-1:0] wgt_o
);
   generate
      if (CRS_W < 2) begin : g_bad_crs
         $error("seg_weight: CRS_W must be at least 2");
      end
   endgenerate

   // 2c+1-2^CRS_W in CRS_W+1 bits is {c,1} with the top bit inverted
   always_comb begin
      wgt_o = {~crs_i[CRS_W-1], crs_i[CRS_W-2:0], 1'b1};
   end
endmodule

// File: rtl/step_shadow.sv
// Holds the step-error estimate steady between update strobes.
module step_shadow #(
   parameter int STEP_W = 12
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     upd_i,
   input  logic signed [STEP_W-1:0] step_i,
   output logic signed [STEP_W-1:0] step_o
);
   generate
      if (STEP_W < 2) begin : g_bad_step
         $error("step_shadow: STEP_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)        step_o <= '0;
      else if (upd_i) step_o <= step_i;
   end

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      !upd_i |=> $stable(step_o)); // R4
   AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
      upd_i |=> (step_o == $past(step_i))); // R5
endmodule

// File: rtl/seg_mult_stage.sv
// Stage 1: weighted step product and scaled base code, registered.
module seg_mult_stage #(
   parameter int RAW_W  = 10,
   parameter int STEP_W = 12,
   parameter int FRAC_W = 5,
   parameter int WGT_W  = 5,
   parameter int MULT_STYLE = segcorr_pkg::MULT_NATIVE,
   localparam int PROD_W = STEP_W + WGT_W,
   localparam int BASE_W = RAW_W + FRAC_W
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic [RAW_W-1:0]         raw_i,
   input  logic signed [WGT_W-1:0]  wgt_i,
   input  logic signed [STEP_W-1:0] step_i,
   output logic                     vld_o,
   output logic [BASE_W-1:0]        base_o,
   output logic signed [PROD_W-1:0] prod_o
);
   logic signed [PROD_W-1:0] prod_c;

   generate
      if (MULT_STYLE == segcorr_pkg::MULT_NATIVE) begin : g_native
         always_comb begin
            prod_c = PROD_W'(step_i) * PROD_W'(wgt_i);
         end
      end else if (MULT_STYLE == segcorr_pkg::MULT_SHIFTADD) begin : g_shiftadd
         logic signed [PROD_W-1:0] step_x;
         logic signed [PROD_W-1:0] part [WGT_W];
         assign step_x = PROD_W'(step_i);
         for (genvar b = 0; b < WGT_W; b++) begin : g_part
            assign part[b] = wgt_i[b] ? (step_x <<< b) : '0;
         end
         always_comb begin
            prod_c = '0;
            for (int b = 0; b < WGT_W - 1; b++) prod_c = prod_c + part[b];
            prod_c = prod_c - part[WGT_W-1];  // sign bit carries negative weight
         end
      end else begin : g_bad_style
         $error("seg_mult_stage: unknown MULT_STYLE");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o  <= 1'b0;
         base_o <= '0;
         prod_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            base_o <= {raw_i, {FRAC_W{1'b0}}};
            prod_o <= prod_c;
         end
      end
   end

   AST_ZERO_STEP_PASS: assert property (@(posedge clk) disable iff (rst)
      (vld_i && step_i == '0) |=> (prod_o == '0)); // R6
endmodule

// File: rtl/seg_add_stage.sv
// Stage 2: sum of base code and correction into the widened output.
module seg_add_stage #(
   parameter int RAW_W  = 10,
   parameter int STEP_W = 12,
   parameter int FRAC_W = 5,
   parameter int WGT_W  = 5,
   localparam int PROD_W = STEP_W + WGT_W,
   localparam int BASE_W = RAW_W + FRAC_W,
   localparam int OUT_W  = segcorr_pkg::imax(PROD_W, BASE_W + 1) + 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic [BASE_W-1:0]        base_i,
   input  logic signed [PROD_W-1:0] prod_i,
   output logic                     vld_o,
   output logic signed [OUT_W-1:0]  sum_o
);
   localparam longint WMAX = (64'sd1 <<< (WGT_W - 1)) - 1;
   localparam longint SMAG = 64'sd1 <<< (STEP_W - 1);
   localparam longint LO   = -(SMAG * WMAX);
   localparam longint HI   = (((64'sd1 <<< RAW_W) - 1) <<< FRAC_W) + SMAG * WMAX;

   generate
      if (OUT_W > 62) begin : g_bad_out
         $error("seg_add_stage: output too wide for range checking");
      end
   endgenerate

   logic signed [OUT_W-1:0] sum_c;
   always_comb begin
      sum_c = $signed({1'b0, base_i}) + OUT_W'(prod_i);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o <= 1'b0;
         sum_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) sum_o <= sum_c;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (longint'(sum_o) >= LO) && (longint'(sum_o) <= HI)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> $stable(sum_o)); // R8
endmodule

// File: rtl/seg_step_corrector.sv
module seg_step_corrector #(
   parameter int RAW_W      = 10,
   parameter int CRS_W      = 4,
   parameter int STEP_W     = 12,
   parameter int FRAC_W     = 5,
   parameter int MULT_STYLE = segcorr_pkg::MULT_NATIVE,
   localparam int WGT_W  = CRS_W + 1,
   localparam int PROD_W = STEP_W + WGT_W,
   localparam int BASE_W = RAW_W + FRAC_W,
   localparam int OUT_W  = segcorr_pkg::imax(PROD_W, BASE_W + 1) + 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    smp_vld_i,
   input  logic [RAW_W-1:0]        raw_i,
   input  logic [CRS_W-1:0]        crs_i,
   input  logic [STEP_W-1:0]       step_i,
   input  logic                    step_upd_i,
   output logic [OUT_W-1:0]        corr_o,
   output logic                    corr_vld_o
);
   generate
      if (FRAC_W >= STEP_W) begin : g_bad_frac
         $error("seg_step_corrector: FRAC_W must be below STEP_W");
      end
   endgenerate

   logic signed [STEP_W-1:0] step_held;
   logic signed [WGT_W-1:0]  wgt;
   logic                     s1_vld;
   logic [BASE_W-1:0]        s1_base;
   logic signed [PROD_W-1:0] s1_prod;
   logic signed [OUT_W-1:0]  s2_sum;

   step_shadow #(.STEP_W(STEP_W)) i_shadow (
      .clk(clk), .rst(rst), .upd_i(step_upd_i),
      .step_i($signed(step_i)), .step_o(step_held)
   );

   seg_weight #(.CRS_W(CRS_W)) i_weight (
      .crs_i(crs_i), .wgt_o(wgt)
   );

   seg_mult_stage #(
      .RAW_W(RAW_W), .STEP_W(STEP_W), .FRAC_W(FRAC_W),
      .WGT_W(WGT_W), .MULT_STYLE(MULT_STYLE)
   ) i_mult (
      .clk(clk), .rst(rst), .vld_i(smp_vld_i), .raw_i(raw_i),
      .wgt_i(wgt), .step_i(step_held),
      .vld_o(s1_vld), .base_o(s1_base), .prod_o(s1_prod)
   );

   seg_add_stage #(
      .RAW_W(RAW_W), .STEP_W(STEP_W), .FRAC_W(FRAC_W), .WGT_W(WGT_W)
   ) i_add (
      .clk(clk), .rst(rst), .vld_i(s1_vld), .base_i(s1_base),
      .prod_i(s1_prod), .vld_o(corr_vld_o), .sum_o(s2_sum)
   );

   assign corr_o = s2_sum;
endmodule

// File: tb/test_seg_step_corrector.sv
module test_seg_step_corrector;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        smp_vld_i = 1'b0;
   logic [9:0]  raw_i = '0;
   logic [3:0]  crs_i = '0;
   logic [11:0] step_i = '0;
   logic        step_upd_i = 1'b0;
   logic [17:0] corr_o;
   logic        corr_vld_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   int    sh_model = 0;
   int    last_e = 0;
   bit    vq1 = 0, vq2 = 0;
   int    dq1 = 0, dq2 = 0;
   string tq1 = "R6", tq2 = "R6";

   always #10 clk = ~clk;

   seg_step_corrector i_seg_step_corrector (
      .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .raw_i(raw_i),
      .crs_i(crs_i), .step_i(step_i), .step_upd_i(step_upd_i),
      .corr_o(corr_o), .corr_vld_o(corr_vld_o)
   );

   function automatic int expect_code(input int r, input int c, input int s);
      return r * 32 + s * (2 * c - 15);
   endfunction

   function automatic int sx12(input logic [11:0] v);
      return (v[11]) ? int'(v) - 4096 : int'(v);
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", req, got, exp);
      end
   endtask

   // compare outputs against the model, then drive one cycle of stimulus
   task automatic cyc(input bit v, input int r, input int c, input int s,
                      input bit u, input string tag);
      int got;
      @(negedge clk);
      got = $signed(corr_o);
      chk("R2", int'(corr_vld_o), int'(vq2));
      chk(tq2, got, dq2);
      smp_vld_i  = v;
      raw_i      = r[9:0];
      crs_i      = c[3:0];
      step_i     = s[11:0];
      step_upd_i = u;
      if (v) last_e = expect_code(r, c, sh_model);
      if (u) sh_model = sx12(s[11:0]);
      vq2 = vq1; dq2 = dq1; tq2 = tq1;
      vq1 = v;   dq1 = last_e; tq1 = tag;
   endtask

   initial begin : watchdog
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // reset state
      chk("R6", int'(corr_vld_o), 0);
      chk("R6", $signed(corr_o), 0);
      rst = 1'b0;
      // pass-through before any strobe, step bus busy
      cyc(1, 700, 3, 1234, 0, "R6");
      cyc(1, 1023, 15, -900, 0, "R6");
      cyc(1, 0, 0, 55, 0, "R6");
      // strobe together with a sample: sample uses old value
      cyc(1, 512, 12, 37, 1, "R5");
      cyc(1, 512, 12, 99, 0, "R5");
      cyc(1, 100, 1, 99, 0, "R5");
      // bus changes with no strobe: ignored
      cyc(1, 300, 2, -500, 0, "R4");
      cyc(1, 300, 13, 2047, 0, "R4");
      cyc(0, 0, 0, -1, 0, "R4");
      cyc(1, 300, 13, -1, 0, "R4");
      // weight table and mirror symmetry
      cyc(0, 0, 0, 64, 1, "R7");
      cyc(1, 512, 0, 0, 0, "R7");
      cyc(1, 512, 7, 0, 0, "R7");
      cyc(1, 512, 8, 0, 0, "R7");
      cyc(1, 512, 15, 0, 0, "R7");
      cyc(1, 512, 3, 0, 0, "R7");
      cyc(1, 512, 12, 0, 0, "R7");
      // negative result and range extremes
      cyc(0, 0, 0, -2048, 1, "R9");
      cyc(1, 0, 15, 0, 0, "R9");
      cyc(1, 5, 13, 0, 0, "R9");
      cyc(1, 1023, 0, 0, 0, "R3");
      cyc(0, 0, 0, 2047, 1, "R3");
      cyc(1, 1023, 15, 0, 0, "R3");
      cyc(1, 0, 0, 0, 0, "R3");
      // idle cycles with junk on the inputs
      for (int i = 0; i < 6; i++)
         cyc(0, int'($urandom_range(1023)), int'($urandom_range(15)),
             int'($urandom_range(4095)), 0, "R8");
      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         bit v, u;
         v = ($urandom_range(9) < 7);
         u = ($urandom_range(31) == 0);
         cyc(v, int'($urandom_range(1023)), int'($urandom_range(15)),
             int'($urandom_range(4095)), u, "R1");
      end
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, "R8");
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule